// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. It is 9 bits wide and 16 words deep by default. Each side has its own enable. The block reports empty, full and half-full. It also reports an almost-empty flag and an almost-full flag, each compared against an offset held in a small register. That offset register starts from one of two default sets, chosen at master reset. Software can reload it either one bit per write clock or a whole offset at a time over the data bus.

A mode input, sampled while master reset is held, selects one of two read timings:

- **Standard timing:** the read flag means "empty", and every word must be requested with a read enable.
- **Fall-through timing:** the head word appears on the output by itself. The read flag then means "output ready" and the write flag means "input ready".

The block has two resets and a rewind:

- **Partial reset** empties the buffer but keeps the offsets and the timing mode.
- **Master reset** restores everything.
- **Retransmit** rewinds the read side to the first stored location, so the data can be read out again.

Pointers cross between the clocks as Gray code through two-stage synchronizers.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words come out in the order they were written, including while writes on `wClk` and reads on `rClk` run at the same time.
- R2: In standard mode, `rdFlag` is 1 exactly when no word is stored, and `wrFlag` is 1 exactly when 16 words (the depth) are stored.
- R3: A write while full and a read while empty are ignored: no pointer moves, no stored word is lost and no word is read twice.
- R4: `halfFull` is 1 when more than 8 words (half the depth) are stored.
- R5: `almostEmpty` is 1 when the stored count is at or below the empty offset. `almostFull` is 1 when the free space is at or below the full offset.
- R6: At master reset, `defSel`=0 loads 1 into both offsets and `defSel`=1 loads 3 into both offsets.
- R7: Parallel load works as follows:
  - Each `wClk` edge with `ldEn`=1 writes `din[3:0]` into an offset.
  - The first such edge after master reset writes the empty offset, the second writes the full offset, and they alternate after that.
  - While `ldEn`=1, no data word is written.
- R8: Serial load works as follows:
  - Each `wClk` edge with `serEn`=1 shifts `serIn` into the offset register.
  - Eight bits are sent, least significant bit first: first the 4 bits of the empty offset, then the 4 bits of the full offset.
- R9: With `modeSel`=1 at master reset (fall-through mode):
  - `rdFlag`=1 means the head word is present on `qOut` without any read.
  - A `rdEn` pulse removes the head word.
  - `wrFlag`=1 means there is room to write.
  - The capacity is 17 words: 16 in the array plus 1 in the output register.
- R10: Master reset clears data and flags and restores the default offsets and the mode selection. Partial reset clears data and flags but keeps the loaded offsets and the mode.
- R11: A `rtEn` pulse on `rClk` rewinds reading to the first word written since the last reset. In standard mode, `rdFlag` shows data again at the next `rClk` edge.
- R12: After a word is written into an empty buffer, the read flag changes within 3 `rClk` rising edges in standard mode and within 4 in fall-through mode.
- R13: While `oe`=0, `qOut` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wClk | input | 1 | Write clock |
| rClk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high; hold it across edges of both clocks |
| prst | input | 1 | Partial reset, active high |
| modeSel | input | 1 | Timing mode sampled during master reset: 0 standard, 1 fall-through |
| defSel | input | 1 | Default offset set sampled during master reset |
| wrEn | input | 1 | Write enable |
| din | input | 9 | Write data; also carries parallel offset values |
| ldEn | input | 1 | Parallel offset load strobe |
| serEn | input | 1 | Serial offset shift enable |
| serIn | input | 1 | Serial offset data bit |
| rdEn | input | 1 | Read enable |
| rtEn | input | 1 | Retransmit (rewind) strobe, read clock domain |
| oe | input | 1 | Output enable for `qOut` |
| qOut | output | 9 | Read data, 0 while `oe` is low |
| rdFlag | output | 1 | Standard: empty. Fall-through: output ready |
| wrFlag | output | 1 | Standard: full. Fall-through: input ready |
| halfFull | output | 1 | More than half the depth is stored |
| almostEmpty | output | 1 | Stored count at or below the empty offset |
| almostFull | output | 1 | Free space at or below the full offset |

## Verification
A write on `wClk` and a read on `rClk` often land close together, because the clocks have 10 ns and 14 ns periods and drift against each other. The bench provokes this by pre-filling eight words and then running a writer and a reader in parallel, each pacing itself only by its own conservative flag. Every word read is judged against the arithmetic pattern expected for its position in the stream, so a lost, doubled or reordered word shows up at once. A second coincidence, an offset load on the same edge as a write enable, is judged by checking that the buffer is still empty afterwards.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  // strobes the control half hands to the datapath half
  typedef struct packed {
    logic wrStrobe;   // store din at wrAddr (write clock)
    logic rdLoad;     // load output register from rdAddr (read clock)
    logic ofsLoad;    // parallel offset load (write clock)
    logic ofsShift;   // serial offset shift (write clock)
  } dcfStrobes_t;
endpackage

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= grayIn;
      stage2 <= stage1;
    end
  end

  // Gray to binary: each bit is the parity of itself and all higher bits
  for (genvar i = 0; i < W; i++) begin : g_bin
    assign binOut[i] = ^stage2[W-1:i];
  end
endmodule

// File: rtl/dcf_ctrl.sv
`timescale 1ns/1ps
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              modeSel,
  input  logic              wrEn,
  input  logic              ldEn,
  input  logic              serEn,
  input  logic              rdEn,
  input  logic              rtEn,
  input  logic [ADDR_W-1:0] emptyOff,
  input  logic [ADDR_W-1:0] fullOff,
  output dcfStrobes_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rstAny,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int PW = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_V = PW'(DEPTH / 2);

  assign rstAny = mrst | prst;

  // ---------------- write domain ----------------
  logic          fwftW;
  logic [PW-1:0] wPtr, wGray, wPtrNext, rSyncBin, wCount;
  logic          full, doWrite;
  logic [PW-1:0] rGray;

  always_ff @(posedge wClk) begin
    if (mrst) fwftW <= modeSel;
  end

  assign wCount   = wPtr - rSyncBin;
  assign full     = (wCount >= DEPTH_V);
  assign doWrite  = wrEn & ~ldEn & ~full;
  assign wPtrNext = wPtr + PW'(1);

  always_ff @(posedge wClk or posedge rstAny) begin
    if (rstAny) begin
      wPtr  <= '0;
      wGray <= '0;
    end else if (doWrite) begin
      wPtr  <= wPtrNext;
      wGray <= wPtrNext ^ (wPtrNext >> 1);
    end
  end

  dcf_ptr_sync #(.W(PW)) u_rsync (
    .clk(wClk), .rst(rstAny), .grayIn(rGray), .binOut(rSyncBin)
  );

  assign wrFlag     = fwftW ? ~full : full;
  assign halfFull   = (wCount > HALF_V);
  assign almostFull = ((DEPTH_V - wCount) <= {1'b0, fullOff});
  assign wrAddr     = wPtr[ADDR_W-1:0];

  // ---------------- read domain ----------------
  logic          fwftR;
  logic [PW-1:0] rPtr, rPtrNext, wSyncBin, ramCount, totalCount;
  logic          ramEmpty, outValid, doLoad;

  always_ff @(posedge rClk) begin
    if (mrst) fwftR <= modeSel;
  end

  dcf_ptr_sync #(.W(PW)) u_wsync (
    .clk(rClk), .rst(rstAny), .grayIn(wGray), .binOut(wSyncBin)
  );

  assign ramCount = wSyncBin - rPtr;
  assign ramEmpty = (ramCount == '0);
  assign rPtrNext = rPtr + PW'(1);
  assign doLoad   = ~ramEmpty & ~rtEn & (fwftR ? (~outValid | rdEn) : rdEn);

  always_ff @(posedge rClk or posedge rstAny) begin
    if (rstAny) begin
      rPtr     <= '0;
      rGray    <= '0;
      outValid <= 1'b0;
    end else if (rtEn) begin
      rPtr     <= '0;
      rGray    <= '0;
      outValid <= 1'b0;
    end else if (doLoad) begin
      rPtr     <= rPtrNext;
      rGray    <= rPtrNext ^ (rPtrNext >> 1);
      outValid <= fwftR;
    end else if (rdEn & outValid) begin
      outValid <= 1'b0;
    end
  end

  assign totalCount  = ramCount + PW'(fwftR & outValid);
  assign rdFlag      = fwftR ? outValid : ramEmpty;
  assign almostEmpty = (totalCount <= {1'b0, emptyOff});
  assign rdAddr      = rPtr[ADDR_W-1:0];

  always_comb begin
    strb          = '0;
    strb.wrStrobe = doWrite;
    strb.rdLoad   = doLoad;
    strb.ofsLoad  = ldEn;
    strb.ofsShift = serEn & ~ldEn;
  end

  // ---------------- assertions ----------------
  a_r3_no_overflow: assert property (@(posedge wClk) disable iff (rstAny)
    full |=> $stable(wPtr));

  a_r2_count_bound: assert property (@(posedge wClk) disable iff (rstAny)
    wCount <= DEPTH_V);

  a_r3_no_underflow: assert property (@(posedge rClk) disable iff (rstAny)
    (ramEmpty && !rtEn) |=> $stable(rPtr));

  a_r11_rewind: assert property (@(posedge rClk) disable iff (rstAny)
    rtEn |=> (rPtr == '0));

  a_r9_ready_drop: assert property (@(posedge rClk) disable iff (rstAny)
    $fell(outValid) |-> ($past(rdEn) || $past(rtEn)));
endmodule

// File: rtl/dcf_datapath.sv
`timescale 1ns/1ps
module dcf_datapath
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 4,
  parameter int OFF_DEF_A = 1,
  parameter int OFF_DEF_B = 3
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              mrst,
  input  logic              rstAny,
  input  logic              defSel,
  input  dcfStrobes_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  input  logic              serIn,
  input  logic              oe,
  output logic [DATA_W-1:0] qOut,
  output logic [ADDR_W-1:0] emptyOff,
  output logic [ADDR_W-1:0] fullOff
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] DEF_A = ADDR_W'(OFF_DEF_A);
  localparam logic [ADDR_W-1:0] DEF_B = ADDR_W'(OFF_DEF_B);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] qReg;
  logic              ldSel;   // 0: next parallel load targets empty offset

  always_ff @(posedge wClk) begin
    if (strb.wrStrobe) mem[wrAddr] <= din;
  end

  always_ff @(posedge rClk or posedge rstAny) begin
    if (rstAny) qReg <= '0;
    else if (strb.rdLoad) qReg <= mem[rdAddr];
  end

  assign qOut = oe ? qReg : '0;

  // offset register: defaults on master reset only, survives partial reset
  always_ff @(posedge wClk) begin
    if (mrst) begin
      emptyOff <= defSel ? DEF_B : DEF_A;
      fullOff  <= defSel ? DEF_B : DEF_A;
      ldSel    <= 1'b0;
    end else if (strb.ofsLoad) begin
      if (!ldSel) emptyOff <= din[ADDR_W-1:0];
      else        fullOff  <= din[ADDR_W-1:0];
      ldSel <= ~ldSel;
    end else if (strb.ofsShift) begin
      {fullOff, emptyOff} <= {serIn, fullOff, emptyOff[ADDR_W-1:1]};
    end
  end

  a_r7_offsets_hold: assert property (@(posedge wClk) disable iff (mrst)
    !(strb.ofsLoad || strb.ofsShift) |=> $stable({emptyOff, fullOff}));
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int ADDR_W    = 4,
  parameter int OFF_DEF_A = 1,
  parameter int OFF_DEF_B = 3
) (
  input  logic              wClk,
  input  logic              rClk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              modeSel,
  input  logic              defSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] din,
  input  logic              ldEn,
  input  logic              serEn,
  input  logic              serIn,
  input  logic              rdEn,
  input  logic              rtEn,
  input  logic              oe,
  output logic [DATA_W-1:0] qOut,
  output logic              rdFlag,
  output logic              wrFlag,
  output logic              halfFull,
  output logic              almostEmpty,
  output logic              almostFull
);
  dcfStrobes_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr, emptyOff, fullOff;
  logic              rstAny;

  dcf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wClk(wClk), .rClk(rClk), .mrst(mrst), .prst(prst), .modeSel(modeSel),
    .wrEn(wrEn), .ldEn(ldEn), .serEn(serEn), .rdEn(rdEn), .rtEn(rtEn),
    .emptyOff(emptyOff), .fullOff(fullOff), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .rstAny(rstAny),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  dcf_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OFF_DEF_A(OFF_DEF_A), .OFF_DEF_B(OFF_DEF_B)
  ) u_dp (
    .wClk(wClk), .rClk(rClk), .mrst(mrst), .rstAny(rstAny), .defSel(defSel),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr), .din(din), .serIn(serIn),
    .oe(oe), .qOut(qOut), .emptyOff(emptyOff), .fullOff(fullOff)
  );
endmodule

// File: tb/dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb_top;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic wClk = 0, rClk = 0;
  logic mrst = 1, prst = 0, modeSel = 0, defSel = 0;
  logic wrEn = 0, ldEn = 0, serEn = 0, serIn = 0, rdEn = 0, rtEn = 0, oe = 1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] qOut;
  logic rdFlag, wrFlag, halfFull, almostEmpty, almostFull;

  int checks = 0;
  int errors = 0;

  always #5 wClk = ~wClk;   // 100 MHz write clock
  always #7 rClk = ~rClk;   // unrelated read clock

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFF_DEF_A(1), .OFF_DEF_B(3)) dut_i (
    .wClk(wClk), .rClk(rClk), .mrst(mrst), .prst(prst), .modeSel(modeSel),
    .defSel(defSel), .wrEn(wrEn), .din(din), .ldEn(ldEn), .serEn(serEn),
    .serIn(serIn), .rdEn(rdEn), .rtEn(rtEn), .oe(oe), .qOut(qOut),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .halfFull(halfFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 37 + 5) % 512);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rClk);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    @(negedge wClk); wrEn = 1; din = v;
    @(negedge wClk); wrEn = 0;
  endtask

  task automatic rd(output logic [DW-1:0] v);
    @(negedge rClk); rdEn = 1;
    @(negedge rClk); rdEn = 0; v = qOut;
  endtask

  task automatic pop();
    @(negedge rClk); rdEn = 1;
    @(negedge rClk); rdEn = 0;
  endtask

  task automatic masterReset(input logic m, input logic s);
    @(negedge wClk); mrst = 1; modeSel = m; defSel = s;
    repeat (4) @(negedge rClk);
    mrst = 0;
    settle();
  endtask

  task automatic partialReset();
    @(negedge wClk); prst = 1;
    repeat (3) @(negedge rClk);
    prst = 0;
    settle();
  endtask

  task automatic parLoad(input int v);
    @(negedge wClk); ldEn = 1; wrEn = 1; din = DW'(v);
    @(negedge wClk); ldEn = 0; wrEn = 0;
  endtask

  task automatic serLoad(input int eOff, input int fOff);
    logic [2*AW-1:0] bits;
    bits = {AW'(fOff), AW'(eOff)};
    for (int i = 0; i < 2 * AW; i++) begin
      @(negedge wClk); serEn = 1; serIn = bits[i];
    end
    @(negedge wClk); serEn = 0;
  endtask

  task automatic flags(input string tag, input int n, input int ae, input int af);
    chk($sformatf("R2 empty n=%0d", n), rdFlag, n == 0);
    chk($sformatf("R2 full n=%0d", n), wrFlag, n == DEPTH);
    chk($sformatf("R4 halfFull n=%0d", n), halfFull, n > DEPTH / 2);
    chk($sformatf("R5 %s almostEmpty n=%0d", tag, n), almostEmpty, n <= ae);
    chk($sformatf("R5 %s almostFull n=%0d", tag, n), almostFull, (DEPTH - n) <= af);
  endtask

  // fill level sweep 0..DEPTH and back, standard mode
  task automatic sweep(input string tag, input int ae, input int af, input int base);
    logic [DW-1:0] d;
    partialReset();
    for (int n = 0; n <= DEPTH; n++) begin
      if (n > 0) wr(pat(base + n - 1));
      settle();
      flags(tag, n, ae, af);
    end
    wr(9'h1AA);
    settle();
    chk("R3 write while full keeps full", wrFlag, 1);
    for (int n = DEPTH; n >= 1; n--) begin
      rd(d);
      chk($sformatf("R1 order idx=%0d", DEPTH - n), d, pat(base + DEPTH - n));
      settle();
      flags(tag, n - 1, ae, af);
    end
    rd(d);
    settle();
    chk("R3 read while empty keeps empty", rdFlag, 1);
    wr(pat(base + 50));
    settle();
    rd(d);
    chk("R3 next word after empty read", d, pat(base + 50));
    settle();
  endtask

  initial begin : main
    logic [DW-1:0] d;
    int k;

    // ---- reset state, standard mode, default set A
    masterReset(0, 0);
    chk("R10 reset rdFlag", rdFlag, 1);
    chk("R10 reset wrFlag", wrFlag, 0);
    chk("R10 reset halfFull", halfFull, 0);
    chk("R10 reset almostEmpty", almostEmpty, 1);
    chk("R10 reset almostFull", almostFull, 0);
    chk("R10 reset qOut", qOut, 0);

    // ---- first word latency, standard
    @(negedge wClk); wrEn = 1; din = 9'h0C3;
    @(posedge wClk); #1 wrEn = 0;
    k = 0;
    while (k < 8) begin
      @(posedge rClk); #1; k++;
      if (!rdFlag) break;
    end
    chk("R12 standard latency within 3", (k >= 1 && k <= 3), 1);
    rd(d);
    chk("R12 first word value", d, 9'h0C3);
    settle();

    // ---- default offsets
    sweep("R6", 1, 1, 0);
    masterReset(0, 1);
    sweep("R6", 3, 3, 100);

    // ---- parallel load, write enable held during load
    masterReset(0, 0);
    parLoad(5);
    parLoad(2);
    settle();
    chk("R7 no word written during load", rdFlag, 1);
    sweep("R7", 5, 2, 200);

    // ---- partial reset keeps offsets
    wr(pat(1)); wr(pat(2)); wr(pat(3));
    settle();
    partialReset();
    chk("R10 partial reset empties", rdFlag, 1);
    chk("R10 partial reset clears halfFull", halfFull, 0);
    sweep("R10", 5, 2, 300);

    // ---- serial load
    serLoad(6, 4);
    sweep("R8", 6, 4, 400);

    // ---- master reset restores defaults
    masterReset(0, 0);
    sweep("R10", 1, 1, 500);

    // ---- fall-through mode
    masterReset(1, 0);
    chk("R9 reset output not ready", rdFlag, 0);
    chk("R9 reset input ready", wrFlag, 1);
    @(negedge wClk); wrEn = 1; din = 9'h12D;
    @(posedge wClk); #1 wrEn = 0;
    k = 0;
    while (k < 8) begin
      @(posedge rClk); #1; k++;
      if (rdFlag) break;
    end
    chk("R12 fall-through latency within 4", (k >= 1 && k <= 4), 1);
    chk("R9 head word without read", qOut, 9'h12D);
    pop();
    settle();
    chk("R9 empty after pop", rdFlag, 0);
    for (int i = 0; i < DEPTH + 1; i++) wr(pat(600 + i));
    settle();
    chk("R9 no room after 17 words", wrFlag, 0);
    chk("R9 almostEmpty low when filled", almostEmpty, 0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      @(negedge rClk);
      chk($sformatf("R9 ready idx=%0d", i), rdFlag, 1);
      chk($sformatf("R9 head idx=%0d", i), qOut, pat(600 + i));
      rdEn = 1;
      @(negedge rClk); rdEn = 0;
    end
    settle();
    chk("R9 drained not ready", rdFlag, 0);
    chk("R9 drained input ready", wrFlag, 1);
    wr(pat(1)); wr(pat(2));
    settle();
    partialReset();
    chk("R10 partial reset keeps fall-through rdFlag", rdFlag, 0);
    chk("R10 partial reset keeps fall-through wrFlag", wrFlag, 1);

    // ---- retransmit and output enable, standard mode
    masterReset(0, 0);
    for (int i = 0; i < 5; i++) wr(pat(700 + i));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd(d);
      chk($sformatf("R11 first pass idx=%0d", i), d, pat(700 + i));
    end
    oe = 0;
    #1;
    chk("R13 qOut zero while disabled", qOut, 0);
    oe = 1;
    #1;
    chk("R13 qOut back when enabled", qOut, pat(702));
    @(negedge rClk); rtEn = 1;
    @(negedge rClk); rtEn = 0;
    chk("R11 data visible right after rewind", rdFlag, 0);
    for (int i = 0; i < 5; i++) begin
      rd(d);
      chk($sformatf("R11 replay idx=%0d", i), d, pat(700 + i));
    end
    settle();
    chk("R11 empty after replay", rdFlag, 1);

    // ---- concurrent writes and reads
    masterReset(0, 0);
    for (int i = 0; i < 8; i++) wr(pat(800 + i));
    settle();
    fork
      begin : writer
        int wk;
        wk = 0;
        while (wk < 40) begin
          @(negedge wClk);
          if (!wrFlag) begin
            wrEn = 1; din = pat(808 + wk);
            @(negedge wClk); wrEn = 0;
            wk++;
          end
        end
      end
      begin : reader
        int rk;
        rk = 0;
        while (rk < 48) begin
          @(negedge rClk);
          if (!rdFlag) begin
            rdEn = 1;
            @(negedge rClk); rdEn = 0;
            chk($sformatf("R1 concurrent idx=%0d", rk), qOut, pat(800 + rk));
            rk++;
          end
        end
      end
    join
    settle();
    chk("R1 empty after stream", rdFlag, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule